// File: doc/BRIEF.md
# Frequency Sweep Controller

This block produces the 48-bit tuning word that drives a numerically controlled oscillator when the oscillator is swept rather than held at a fixed frequency. It has two sweep modes. In linear chirp mode the word advances by a programmed increment at a programmed pace, so it can cover a wide band. In ramped FSK mode the word travels gradually between two programmed end frequencies, in the direction selected by a direction pin. It comes to rest exactly on whichever end it is heading for.

Four registers are loaded through a simple write strobe with an address: the low end frequency, the high end frequency, the step size, and a 20-bit pace value. A hold pin freezes the tuning word and the pace counter together. The sweep carries on from the same point when hold is released.

Top module: `freq_sweeper`

## Requirements
- R1: After reset the tuning word, both end frequencies, the step size, the pace value and the pace counter are all zero.
- R2: A step is taken on a clock edge where hold is low and the pace counter is at or above the pace value. The counter then returns to zero. On any other edge with hold low the counter increments. With the pace value P, and nothing else changing the word, steps therefore fall every P+1 clocks.
- R3: In linear chirp mode (`ramp_mode` = 0), each step adds the step size to the tuning word, modulo 2^48.
- R4: In ramped FSK mode (`ramp_mode` = 1) the target is end frequency 2 while `fsk_dir` is 1 and end frequency 1 while it is 0. Each step moves the word toward the target by the step size.
- R5: When the remaining distance to the target is no larger than the step size, a step lands exactly on the target and never passes it.
- R6: In ramped FSK mode, once the word equals the target, further steps leave it unchanged.
- R7: While `hold` is 1 the tuning word and the pace counter keep their values. After release, the counter resumes from its stored count.
- R8: Writes use `wr_addr` 0 for end frequency 1, 1 for end frequency 2, 2 for the step size and 3 for the pace value. They take effect from the next clock. A write to address 0 while `ramp_mode` is 0 also loads the tuning word with the written value. This load takes priority over a step and over hold. No other write changes the tuning word directly.
- R9: A write to address 3 keeps only bits 19:0 of `wr_data` as the pace value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ramp_mode | input | 1 | 0 selects linear chirp, 1 selects ramped FSK |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for the write |
| wr_data | input | 48 | Write data |
| fsk_dir | input | 1 | Ramped FSK direction: 1 heads to end frequency 2, 0 to end frequency 1 |
| hold | input | 1 | Freezes the tuning word and pace counter |
| ftw | output | 48 | Tuning word to the oscillator |

## Verification
The reference model is tested with several stimulus patterns:
- A chirp from a loaded start word, which shows the pace spacing and the add step.
- A chirp that crosses 2^48, which shows the modulo wrap.
- Ramped FSK runs in both directions with a span that the step does not divide evenly, which separate correct saturation from overshoot or from stopping one step short.
- Reversing `fsk_dir` partway through a ramp, which shows that the target is picked live.
- Hold pulses placed in the middle of a pace interval, which separate a counter that keeps its count from one that restarts.
- Writes of a pace value with high bits set, and writes of end frequencies during a ramp, which show which bits are kept and that no jump occurs.

// File: rtl/freq_sweeper.sv
module freq_sweeper #(
  parameter int FW = 48,
  parameter int RW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ramp_mode,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [FW-1:0] wr_data,
  input  logic          fsk_dir,
  input  logic          hold,
  output logic [FW-1:0] ftw
);

  logic [FW-1:0] f1_q, f2_q, dlt_q, ftw_q;
  logic [RW-1:0] rate_q, cnt_q;

  logic          tick, load, up;
  logic [FW-1:0] target, gap, ramp_nxt, step_nxt;

  assign tick   = !hold && (cnt_q >= rate_q);
  assign load   = wr_en && (wr_addr == 2'd0) && !ramp_mode;
  assign target = fsk_dir ? f2_q : f1_q;
  assign up     = ftw_q < target;
  assign gap    = up ? (target - ftw_q) : (ftw_q - target);

  assign ramp_nxt = (gap <= dlt_q) ? target :
                    up ? (ftw_q + dlt_q) : (ftw_q - dlt_q);
  assign step_nxt = ramp_mode ? ramp_nxt : (ftw_q + dlt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f1_q   <= '0;
      f2_q   <= '0;
      dlt_q  <= '0;
      rate_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0:    f1_q   <= wr_data;
        2'd1:    f2_q   <= wr_data;
        2'd2:    dlt_q  <= wr_data;
        default: rate_q <= wr_data[RW-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (tick)  cnt_q <= '0;
    else if (!hold) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    ftw_q <= '0;
    else if (load) ftw_q <= wr_data;
    else if (tick) ftw_q <= step_nxt;
  end

  assign ftw = ftw_q;

endmodule

module freq_sweeper_chk #(
  parameter int FW = 48,
  parameter int RW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ramp_mode,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic          fsk_dir,
  input logic          hold,
  input logic [FW-1:0] ftw,
  input logic [FW-1:0] f1_q,
  input logic [FW-1:0] f2_q,
  input logic [RW-1:0] rate_q,
  input logic [RW-1:0] cnt_q
);

  logic          ld;
  logic [FW-1:0] tgt;
  assign ld  = wr_en && (wr_addr == 2'd0) && !ramp_mode;
  assign tgt = fsk_dir ? f2_q : f1_q;

  // R7
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !ld) |=> ftw == $past(ftw));

  // R7
  hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> cnt_q == $past(cnt_q));

  // R2
  no_early_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && cnt_q < rate_q) |=> ftw == $past(ftw));

  // R5
  no_overshoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_mode && ftw <= tgt) |=> ftw <= $past(tgt));

  // R5
  no_undershoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_mode && ftw >= tgt) |=> ftw >= $past(tgt));

  // R6
  rest_at_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_mode && ftw == tgt) |=> ftw == $past(ftw));

endmodule

bind freq_sweeper freq_sweeper_chk #(.FW(FW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ramp_mode(ramp_mode), .wr_en(wr_en),
  .wr_addr(wr_addr), .fsk_dir(fsk_dir), .hold(hold), .ftw(ftw),
  .f1_q(f1_q), .f2_q(f2_q), .rate_q(rate_q), .cnt_q(cnt_q)
);

// File: tb/freq_sweeper_bench.sv
module freq_sweeper_bench;
  localparam int PERIOD = 10;
  localparam logic [47:0] TOP = 48'hFFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ramp_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [47:0] wr_data = '0;
  logic        fsk_dir = 1'b0;
  logic        hold = 1'b0;
  logic [47:0] ftw;

  freq_sweeper u_freq_sweeper (
    .clk(clk), .rst_n(rst_n), .ramp_mode(ramp_mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .fsk_dir(fsk_dir),
    .hold(hold), .ftw(ftw)
  );

  always #(PERIOD/2) clk = ~clk;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    live = 0;
  string phase = "R1";

  logic [47:0] m_f1 = '0, m_f2 = '0, m_dlt = '0, m_ftw = '0;
  int          m_rate = 0, m_cnt = 0;

  task automatic chk(string req, logic [47:0] act, logic [47:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: ftw actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_f1 = '0; m_f2 = '0; m_dlt = '0; m_ftw = '0; m_rate = 0; m_cnt = 0;
    end else begin
      logic        tick;
      logic [47:0] nxt, tg;
      tick = !hold && (m_cnt >= m_rate);
      nxt = m_ftw;
      if (tick) begin
        if (!ramp_mode) nxt = m_ftw + m_dlt;
        else begin
          tg = fsk_dir ? m_f2 : m_f1;
          if (m_ftw < tg) nxt = (tg - m_ftw <= m_dlt) ? tg : m_ftw + m_dlt;
          else if (m_ftw > tg) nxt = (m_ftw - tg <= m_dlt) ? tg : m_ftw - m_dlt;
        end
      end
      if (wr_en && wr_addr == 2'd0 && !ramp_mode) nxt = wr_data;
      if (tick) m_cnt = 0;
      else if (!hold) m_cnt = m_cnt + 1;
      m_ftw = nxt;
      if (wr_en) begin
        case (wr_addr)
          2'd0: m_f1 = wr_data;
          2'd1: m_f2 = wr_data;
          2'd2: m_dlt = wr_data;
          default: m_rate = int'(wr_data[19:0]);
        endcase
      end
    end
  end

  always @(negedge clk) if (live) chk(phase, ftw, m_ftw);

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [47:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", ftw, '0);
    live = 1;

    phase = "R8"; wr(2'd2, 48'd5); wr(2'd3, 48'd2); wr(2'd0, 48'd100);
    phase = "R2"; idle(2);
    phase = "R3"; idle(12);

    phase = "R3"; wr(2'd0, TOP - 48'd2); idle(12);

    phase = "R9"; wr(2'd3, 48'hABCD_0000_0001); idle(10);

    phase = "R8"; wr(2'd3, 48'd0); wr(2'd0, 48'd1000); wr(2'd1, 48'd1023);
    @(negedge clk); ramp_mode = 1'b1; fsk_dir = 1'b1;
    phase = "R4"; idle(3);
    phase = "R5"; idle(5);
    chk("R5", ftw, 48'd1023);
    phase = "R6"; idle(4);
    chk("R6", ftw, 48'd1023);

    phase = "R4"; fsk_dir = 1'b0; idle(2); fsk_dir = 1'b1; idle(1); fsk_dir = 1'b0; idle(8);
    chk("R5", ftw, 48'd1000);

    phase = "R7"; wr(2'd3, 48'd3); fsk_dir = 1'b1; idle(2);
    hold = 1'b1; idle(5); hold = 1'b0; idle(3);
    hold = 1'b1; idle(2); hold = 1'b0; idle(20);

    phase = "R8"; fsk_dir = 1'b0; wr(2'd0, 48'd900); wr(2'd1, 48'd2000); idle(20);
    @(negedge clk); ramp_mode = 1'b0; hold = 1'b1;
    wr(2'd0, 48'd77); idle(3);
    chk("R8", ftw, 48'd77);
    hold = 1'b0; idle(10);

    live = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule